// File: doc/BRIEF.md
# Nibble-Field 8-bit Register Machine Core

This block is a small single-issue processor core. It has sixteen 8-bit general registers and a 256-byte memory inside the block. Every instruction is a 16-bit word split into four 4-bit fields: an opcode followed by three operand fields. The core fetches each instruction as two bytes, decodes it and executes it. It stops on a halt instruction or on an opcode it does not implement.

A test environment loads a program while the core is held in reset, using a byte-wide preload write port. After reset is released, execution begins at the address set by the `START_ADDR` parameter. While the core runs or after it stops, three debug outputs let the environment inspect its state:
- the program counter;
- a register read port;
- a memory read port.

Top module: `nib_core`

## Requirements
- R1: While `rst` is high, the core sets `pc_out` to `START_ADDR`, clears `halted`, `illegal` and all sixteen registers, and writes `pl_data` into memory at `pl_addr` on every cycle where `pl_we` is high.
- R2: While `rst` is low, the preload port has no effect on memory.
- R3: An instruction occupies two consecutive bytes, with the opcode byte (instruction bits 15:8) at the lower address. Each instruction takes three cycles: one fetch cycle per byte, then one execute cycle. `pc_out` advances by 2 at the end of the second cycle, so the first step after reset shows up two cycles after release.
- R4: Opcode 2, written `2RXY`, loads the immediate byte XY into register R.
- R5: Opcode 1, written `1RXY`, loads register R from memory address XY. Opcode 3, written `3RXY`, writes register R to memory address XY. The loaded value is ready for the next instruction.
- R6: Opcode 4, written `40RS`, copies register R (bits 7:4) into register S (bits 3:0).
- R7: Opcode 5, written `5RST`, writes S+T modulo 256 into register R. No flags are kept.
- R8: Opcode 7, written `7RST`, writes S OR T into register R. Opcode 8, written `8RST`, writes S AND T into register R.
- R9: Opcode A, written `AR0X`, rotates register R right by X modulo 8 positions. Bits that leave bit 0 re-enter at bit 7, and a count of 0 leaves R unchanged.
- R10: The word C000 sets `halted`. The core then stops with `pc_out` at the halt address plus 2, and the counter, registers and memory stay unchanged until reset.
- R11: Opcodes 0, 6, 9, B, D, E and F, and opcode C with any non-zero operand, set `illegal` instead of `halted`. The core stops without executing the word and stays frozen as in R10. `halted` and `illegal` are never both high.
- R12: `dbg_reg_data` shows the register selected by `dbg_reg_sel` one cycle later, and `dbg_mem_data` shows the memory byte at `dbg_mem_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; preload window |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 8 | Preload byte address |
| pl_data | input | 8 | Preload byte |
| dbg_reg_sel | input | 4 | Debug register select |
| dbg_reg_data | output | 8 | Selected register, registered |
| dbg_mem_addr | input | 8 | Debug memory address |
| dbg_mem_data | output | 8 | Selected memory byte, registered |
| pc_out | output | 8 | Program counter |
| halted | output | 1 | Halt word executed |
| illegal | output | 1 | Unimplemented word met |

## Verification
The program counter is sampled in the falling-edge half after each rising edge. The bench expects `START_ADDR` one cycle after reset is released and `START_ADDR`+2 one cycle after that. Both debug ports are registered, so the bench drives the select on a falling edge and samples one full cycle later. For each program, the bench waits for `halted` or `illegal` and only then reads registers and memory, so the three-cycle instruction pace never sets when results are read. The frozen state is checked by waiting extra cycles and comparing the counter and the registers again.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int WORD_W = 8;
  localparam int FLD_W  = 4;
  localparam int NREG   = 1 << FLD_W;
  localparam int MEM_D  = 1 << WORD_W;

  typedef enum logic [1:0] {ST_F1, ST_F2, ST_EX, ST_STOP} core_st_t;

  localparam logic [FLD_W-1:0] OP_LDM = 4'h1;
  localparam logic [FLD_W-1:0] OP_LDI = 4'h2;
  localparam logic [FLD_W-1:0] OP_STR = 4'h3;
  localparam logic [FLD_W-1:0] OP_MOV = 4'h4;
  localparam logic [FLD_W-1:0] OP_ADD = 4'h5;
  localparam logic [FLD_W-1:0] OP_IOR = 4'h7;
  localparam logic [FLD_W-1:0] OP_AND = 4'h8;
  localparam logic [FLD_W-1:0] OP_ROR = 4'hA;
  localparam logic [FLD_W-1:0] OP_HLT = 4'hC;
endpackage

// File: rtl/nib_mem.sv
module nib_mem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
  parameter int DW = 8,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [RW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic [RW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  localparam int N = 1 << RW;
  logic [DW-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else if (we && waddr == RW'(i)) regs[i] <= wdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= regs[dbg_addr];
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [FLD_W-1:0] op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [FLD_W-1:0] cnt,
  output logic [DW-1:0]    y
);
  localparam int CW = $clog2(DW);
  logic [CW-1:0]   sh;
  logic [2*DW-1:0] dbl;

  assign sh  = cnt[CW-1:0];
  assign dbl = {a, a} >> sh;

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_IOR:  y = a | b;
      OP_AND:  y = a & b;
      OP_ROR:  y = dbl[DW-1:0];
      default: y = a;
    endcase
  end
endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_pkg::*;
#(
  parameter logic [7:0] START_ADDR = 8'h10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pl_we,
  input  logic [7:0]  pl_addr,
  input  logic [7:0]  pl_data,
  input  logic [3:0]  dbg_reg_sel,
  output logic [7:0]  dbg_reg_data,
  input  logic [7:0]  dbg_mem_addr,
  output logic [7:0]  dbg_mem_data,
  output logic [7:0]  pc_out,
  output logic        halted,
  output logic        illegal
);
  localparam int DW = WORD_W;
  localparam int AW = WORD_W;

  core_st_t         st;
  logic [AW-1:0]    pc;
  logic [DW-1:0]    ir_hi;
  logic             ld_pend;
  logic [FLD_W-1:0] ld_reg;

  logic [DW-1:0]    m_rdata, m_wdata;
  logic [AW-1:0]    m_addr;
  logic             m_we;

  logic             r_we;
  logic [FLD_W-1:0] r_waddr, ra_addr, rb_addr;
  logic [DW-1:0]    r_wdata, ra_data, rb_data, alu_y;

  logic [2*DW-1:0]  instr;
  logic [FLD_W-1:0] op, f1, f2, f3;
  logic             is_halt, is_legal;

  assign instr = {ir_hi, m_rdata};
  assign op = instr[15:12];
  assign f1 = instr[11:8];
  assign f2 = instr[7:4];
  assign f3 = instr[3:0];

  assign is_halt = (op == OP_HLT) && (instr[11:0] == 12'h000);

  always_comb begin
    case (op)
      OP_LDM, OP_LDI, OP_STR, OP_MOV,
      OP_ADD, OP_IOR, OP_AND, OP_ROR: is_legal = 1'b1;
      default:                        is_legal = is_halt;
    endcase
  end

  // register read operand selection
  assign ra_addr = (op == OP_STR || op == OP_ROR) ? f1 : f2;
  assign rb_addr = f3;

  // memory port A: preload in reset, otherwise fetch / load / store
  always_comb begin
    m_we    = 1'b0;
    m_addr  = pc;
    m_wdata = ra_data;
    if (rst) begin
      m_we    = pl_we;
      m_addr  = pl_addr;
      m_wdata = pl_data;
    end else begin
      case (st)
        ST_F1: m_addr = pc;
        ST_F2: m_addr = pc + AW'(1);
        ST_EX: begin
          m_addr = m_rdata;
          m_we   = (op == OP_STR);
        end
        default: m_addr = pc;
      endcase
    end
  end

  // register write selection
  always_comb begin
    r_we    = 1'b0;
    r_waddr = f1;
    r_wdata = alu_y;
    if (!rst) begin
      if (st == ST_F1 && ld_pend) begin
        r_we    = 1'b1;
        r_waddr = ld_reg;
        r_wdata = m_rdata;
      end else if (st == ST_EX) begin
        case (op)
          OP_LDI: begin r_we = 1'b1; r_wdata = m_rdata; end
          OP_MOV: begin r_we = 1'b1; r_waddr = f3; r_wdata = ra_data; end
          OP_ADD, OP_IOR, OP_AND, OP_ROR: r_we = 1'b1;
          default: r_we = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_F1;
      pc      <= START_ADDR;
      ir_hi   <= '0;
      ld_pend <= 1'b0;
      ld_reg  <= '0;
      halted  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      case (st)
        ST_F1: begin
          ld_pend <= 1'b0;
          st      <= ST_F2;
        end
        ST_F2: begin
          ir_hi <= m_rdata;
          pc    <= pc + AW'(2);
          st    <= ST_EX;
        end
        ST_EX: begin
          ld_reg <= f1;
          if (is_halt) begin
            halted <= 1'b1;
            st     <= ST_STOP;
          end else if (!is_legal) begin
            illegal <= 1'b1;
            st      <= ST_STOP;
          end else begin
            ld_pend <= (op == OP_LDM);
            st      <= ST_F1;
          end
        end
        default: st <= ST_STOP;
      endcase
    end
  end

  assign pc_out = pc;

  nib_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .a_we(m_we), .a_addr(m_addr), .a_wdata(m_wdata),
    .a_rdata(m_rdata), .b_addr(dbg_mem_addr), .b_rdata(dbg_mem_data)
  );

  nib_regfile #(.DW(DW), .RW(FLD_W)) u_rf (
    .clk(clk), .rst(rst), .we(r_we), .waddr(r_waddr), .wdata(r_wdata),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .dbg_addr(dbg_reg_sel), .dbg_data(dbg_reg_data)
  );

  nib_alu #(.DW(DW)) u_alu (
    .op(op), .a(ra_data), .b(rb_data), .cnt(f3), .y(alu_y)
  );
endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk #(
  parameter logic [7:0] START_ADDR = 8'h10
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] pc_out,
  input logic       halted,
  input logic       illegal
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_out == START_ADDR && !halted && !illegal));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_out != $past(pc_out)) |-> (pc_out == $past(pc_out) + 8'd2));

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R10
  stop_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (halted || illegal) |=> $stable(pc_out));

  // R11
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  // R11
  stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halted, illegal}));
endmodule

bind nib_core nib_core_chk #(.START_ADDR(START_ADDR)) u_chk (
  .clk(clk), .rst(rst), .pc_out(pc_out), .halted(halted), .illegal(illegal)
);

// File: tb/sim_nib_core.sv
`timescale 1ns/1ps
module sim_nib_core;
  localparam logic [7:0] START = 8'h10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pl_we = 1'b0;
  logic [7:0] pl_addr = '0, pl_data = '0;
  logic [3:0] dbg_reg_sel = '0;
  logic [7:0] dbg_mem_addr = '0;
  logic [7:0] dbg_reg_data, dbg_mem_data, pc_out;
  logic       halted, illegal;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  nib_core #(.START_ADDR(START)) u0 (
    .clk(clk), .rst(rst), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data),
    .pc_out(pc_out), .halted(halted), .illegal(illegal)
  );

  // {op[27:24], a[23:16], b/count[15:8], expected[7:0]}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {4'h5, 8'hFF, 8'h01, 8'h00},
    {4'h5, 8'h7F, 8'h01, 8'h80},
    {4'h5, 8'h93, 8'h2C, 8'hBF},
    {4'h7, 8'hA0, 8'h05, 8'hA5},
    {4'h7, 8'hF0, 8'h0F, 8'hFF},
    {4'h8, 8'hF0, 8'h3C, 8'h30},
    {4'h8, 8'hAA, 8'h55, 8'h00},
    {4'hA, 8'hB1, 8'h01, 8'hD8},
    {4'hA, 8'hB1, 8'h00, 8'hB1},
    {4'hA, 8'hB1, 8'h09, 8'hD8},
    {4'hA, 8'hB1, 8'h04, 8'h1B},
    {4'hA, 8'h81, 8'h07, 8'h03}
  };

  logic [7:0] prog [32];
  int plen;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] hi, input logic [7:0] lo);
    prog[plen] = hi; prog[plen+1] = lo; plen += 2;
  endtask

  task automatic load_and_run(output bit done);
    @(negedge clk); rst = 1'b1;
    for (int i = 0; i < plen; i++) begin
      pl_we = 1'b1; pl_addr = START + 8'(i); pl_data = prog[i];
      @(negedge clk);
    end
    pl_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    done = 1'b0;
    for (int i = 0; i < 400 && !done; i++) begin
      @(negedge clk);
      done = halted || illegal;
    end
  endtask

  task automatic rd_reg(input logic [3:0] sel, output logic [7:0] v);
    @(negedge clk); dbg_reg_sel = sel;
    @(negedge clk); v = dbg_reg_data;
  endtask

  task automatic rd_mem(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); dbg_mem_addr = a;
    @(negedge clk); v = dbg_mem_data;
  endtask

  initial begin
    #(20ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, p0;
    bit done;

    // reset state and first pc steps (R1, R3)
    repeat (3) @(negedge clk);
    check("R1 pc in reset", pc_out, START);
    check("R1 halted in reset", {7'd0, halted}, 8'h00);
    check("R1 illegal in reset", {7'd0, illegal}, 8'h00);
    rd_reg(4'h7, v);
    check("R1 reg cleared", v, 8'h00);
    plen = 0; put(8'h21, 8'h11); put(8'hC0, 8'h00);
    @(negedge clk); rst = 1'b1;
    for (int i = 0; i < plen; i++) begin
      pl_we = 1'b1; pl_addr = START + 8'(i); pl_data = prog[i];
      @(negedge clk);
    end
    pl_we = 1'b0; rst = 1'b0;
    @(negedge clk);
    check("R3 pc after first cycle", pc_out, START);
    @(negedge clk);
    check("R3 pc after second cycle", pc_out, START + 8'd2);
    repeat (3) @(negedge clk);
    check("R3 pc after second fetch", pc_out, START + 8'd4);
    repeat (3) @(negedge clk);
    check("R10 halted set", {7'd0, halted}, 8'h01);
    rd_reg(4'h1, v);
    check("R4 load immediate", v, 8'h11);

    // vector table (R7, R8, R9)
    for (int k = 0; k < NV; k++) begin
      plen = 0;
      if (VEC[k][27:24] == 4'hA) begin
        put(8'h23, VEC[k][23:16]);
        put(8'hA3, {4'h0, VEC[k][11:8]});
      end else begin
        put(8'h21, VEC[k][23:16]);
        put(8'h22, VEC[k][15:8]);
        put({VEC[k][27:24], 4'h3}, 8'h12);
      end
      put(8'hC0, 8'h00);
      load_and_run(done);
      check("R7 R8 R9 completion", {7'd0, done}, 8'h01);
      rd_reg(4'h3, v);
      check(VEC[k][27:24] == 4'h5 ? "R7 add" :
            VEC[k][27:24] == 4'hA ? "R9 rotate" : "R8 or/and", v, VEC[k][7:0]);
    end

    // load, store, move, load-use (R5, R6, R10)
    plen = 0;
    put(8'h21, 8'h5A); put(8'h31, 8'h40); put(8'h12, 8'h40);
    put(8'h54, 8'h22); put(8'h40, 8'h23); put(8'h33, 8'h41);
    put(8'hC0, 8'h00);
    load_and_run(done);
    check("R10 halted", {7'd0, halted}, 8'h01);
    check("R10 pc after halt", pc_out, START + 8'd14);
    rd_reg(4'h2, v);  check("R5 load from memory", v, 8'h5A);
    rd_reg(4'h4, v);  check("R5 loaded value used next", v, 8'hB4);
    rd_reg(4'h3, v);  check("R6 move", v, 8'h5A);
    rd_mem(8'h40, v); check("R5 store", v, 8'h5A);
    rd_mem(8'h41, v); check("R12 memory debug port", v, 8'h5A);
    p0 = pc_out;
    repeat (10) @(negedge clk);
    check("R10 pc frozen", pc_out, p0);
    rd_reg(4'h4, v);  check("R10 regs frozen", v, 8'hB4);

    // preload ignored outside reset (R2)
    @(negedge clk); pl_we = 1'b1; pl_addr = 8'h41; pl_data = 8'h77;
    @(negedge clk); pl_we = 1'b0;
    rd_mem(8'h41, v); check("R2 preload ignored", v, 8'h5A);

    // illegal opcode (R11)
    plen = 0; put(8'h21, 8'h11); put(8'h90, 8'h00); put(8'h22, 8'h33);
    put(8'hC0, 8'h00);
    load_and_run(done);
    check("R11 illegal set", {7'd0, illegal}, 8'h01);
    check("R11 halted clear", {7'd0, halted}, 8'h00);
    check("R11 pc at stop", pc_out, START + 8'd4);
    rd_reg(4'h2, v);  check("R11 later word not run", v, 8'h00);
    repeat (8) @(negedge clk);
    check("R11 pc frozen", pc_out, START + 8'd4);

    // C with non-zero operand is illegal (R11)
    plen = 0; put(8'hC1, 8'h00); put(8'h22, 8'h33);
    load_and_run(done);
    check("R11 C-nonzero illegal", {7'd0, illegal}, 8'h01);
    check("R11 C-nonzero not halt", {7'd0, halted}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule